// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block sits on the outbound path of a PCIe root-complex bridge. It turns 32-bit local bus addresses into 64-bit PCIe addresses. A small register bank holds three things: a global translate enable, a window-size code, and a table of 32 translation windows. Each window has a low and a high offset word. The size code picks a window size of 2^code megabytes.

Each incoming local address is split into two parts. The upper part selects a window and the lower part is an in-window offset. If the selected window is enabled and translation is on, the window's programmed base replaces the upper address bits and its high word becomes the top 32 bits of the result. Otherwise the address passes through zero-extended and a miss flag is raised.

The address path uses a valid/ready handshake with one registered stage. Software reads and writes the registers through a simple strobe port, and read data comes back one cycle after the read strobe.

Top module: `ob_xlat_top`

## Requirements
- R1: After reset every register reads as zero, out_valid is 0, in_ready is 1, and a lookup passes through with out_miss set.
- R2: The size register at offset 0x030 holds a 3-bit code in bits [2:0]. The window size is 2^(20+code) bytes, and a read returns the code with all other bits zero.
- R3: Bit 1 of the command register at offset 0x004 is the global translate enable. Reads return that bit alone; other written bits are dropped.
- R4: Window n (0..31) has its low offset word at 0x200 + 8n and its high offset word at 0x204 + 8n. Both are full 32-bit read/write words.
- R5: The window index is (address >> (20+code)) modulo 32.
- R6: On a hit (global enable set and bit 0 of the window's low word set), out_addr = {high word, low word bits above the window size, address bits below the window size} and out_miss is 0.
- R7: An address that selects a window whose low-word bit 0 is clear gives out_addr = {32'h0, address} with out_miss 1.
- R8: While the global enable is clear, every lookup passes through zero-extended with out_miss 1, whatever the window table holds.
- R9: An address accepted at a clock edge (in_valid and in_ready) appears on out_addr/out_valid from that edge. in_ready is low while out_valid is high and out_ready is low, and in that state the output holds stable.
- R10: Register read data and reg_rvalid appear one cycle after reg_rd. Unmapped offsets read as zero, and writes to them change no register.
- R11: A lookup accepted on the same edge as a register write uses the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| in_valid | input | 1 | Local address valid |
| in_ready | output | 1 | Lookup stage can accept an address |
| in_addr | input | 32 | Local bus address |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Downstream accepts the translated address |
| out_addr | output | 64 | Translated PCIe address |
| out_miss | output | 1 | Address passed through untranslated |

## Verification
A corrupted table entry, size code or enable bit shows on the next lookup that selects the affected window. It appears one cycle after acceptance, as a wrong upper address field or a flipped miss flag. A wrong index computation shows only for addresses whose upper bits differ between the right window and the wrong one, so the vectors cover several size codes, the modulo-32 wrap, and the last window. A pipeline fault under backpressure shows as a changed out_addr while out_ready is low, or as a lost or duplicated address once it rises again.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;
  // register target selected by the decoder
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_SIZE = 2'd2,
    SEL_WIN  = 2'd3
  } reg_sel_e;

  // log2 of one megabyte, the unit of the window size
  localparam int MB_LOG2 = 20;
endpackage

// File: rtl/ob_xlat_regs.sv
module ob_xlat_regs
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int REG_AW  = 12,
  parameter int DW      = 32,
  parameter int CODE_W  = 3,
  parameter int XEN_BIT = 1,
  parameter logic [REG_AW-1:0] CMD_OFS  = 'h004,
  parameter logic [REG_AW-1:0] SIZE_OFS = 'h030,
  parameter logic [REG_AW-1:0] WIN_OFS  = 'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  output logic              xlat_en,
  output logic [CODE_W-1:0] size_code,
  output logic [DW-1:0]     win_lo [NUM_WIN],
  output logic [DW-1:0]     win_hi [NUM_WIN]
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int SPAN  = NUM_WIN * 8;
  localparam logic [REG_AW:0] WIN_END = {1'b0, WIN_OFS} + (REG_AW+1)'(SPAN);

  reg_sel_e          sel;
  logic [REG_AW-1:0] rel;
  logic [IDX_W-1:0]  widx;
  logic              is_hi;
  logic [DW-1:0]     rd_mux;

  // address decode
  always_comb begin
    rel   = reg_addr - WIN_OFS;
    widx  = rel[IDX_W+2:3];
    is_hi = reg_addr[2];
    sel   = SEL_NONE;
    if (reg_addr[1:0] == 2'b00) begin
      if (reg_addr == CMD_OFS)
        sel = SEL_CMD;
      else if (reg_addr == SIZE_OFS)
        sel = SEL_SIZE;
      else if (reg_addr >= WIN_OFS && {1'b0, reg_addr} < WIN_END)
        sel = SEL_WIN;
    end
  end

  // global controls
  always_ff @(posedge clk) begin
    if (rst) begin
      xlat_en   <= 1'b0;
      size_code <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_CMD)
        xlat_en <= reg_wdata[XEN_BIT];
      if (sel == SEL_SIZE)
        size_code <= reg_wdata[CODE_W-1:0];
    end
  end

  // window table, one pair of words per window
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_lo[w] <= '0;
        win_hi[w] <= '0;
      end else if (reg_wr && sel == SEL_WIN && widx == IDX_W'(w)) begin
        if (is_hi)
          win_hi[w] <= reg_wdata;
        else
          win_lo[w] <= reg_wdata;
      end
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CMD:  rd_mux[XEN_BIT] = xlat_en;
      SEL_SIZE: rd_mux = DW'(size_code);
      SEL_WIN:  rd_mux = is_hi ? win_hi[widx] : win_lo[widx];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd)
        reg_rdata <= rd_mux;
    end
  end

  // R2
  size_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SIZE_OFS) |=> size_code == $past(reg_wdata[CODE_W-1:0]));

  // R3
  cmd_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == CMD_OFS) |=> xlat_en == $past(reg_wdata[XEN_BIT]));

  // R10
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
endmodule

// File: rtl/ob_xlat_lookup.sv
module ob_xlat_lookup
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int AW      = 32,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlat_en,
  input  logic [CODE_W-1:0] size_code,
  input  logic [AW-1:0]     win_lo [NUM_WIN],
  input  logic [AW-1:0]     win_hi [NUM_WIN],
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*AW-1:0]   out_addr,
  output logic              out_miss
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int SH_W  = $clog2(AW) + 1;

  logic [SH_W-1:0]   shamt;
  logic [AW-1:0]     mask;
  logic [AW-1:0]     shifted;
  logic [IDX_W-1:0]  idx;
  logic [AW-1:0]     lo_sel;
  logic              hit;
  logic [2*AW-1:0]   nxt_addr;

  // split the address and merge in the window base
  always_comb begin
    shamt    = SH_W'(MB_LOG2) + SH_W'(size_code);
    mask     = (AW'(1) << shamt) - AW'(1);
    shifted  = in_addr >> shamt;
    idx      = shifted[IDX_W-1:0];
    lo_sel   = win_lo[idx];
    hit      = xlat_en && lo_sel[0];
    if (hit)
      nxt_addr = {win_hi[idx], (lo_sel & ~mask) | (in_addr & mask)};
    else
      nxt_addr = {{AW{1'b0}}, in_addr};
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_miss  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= nxt_addr;
        out_miss <= !hit;
      end
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_miss)));

  // R8
  glob_off_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !xlat_en) |=>
      (out_valid && out_miss && out_addr[2*AW-1:AW] == '0));
endmodule

// File: rtl/ob_xlat_top.sv
module ob_xlat_top #(
  parameter int NUM_WIN = 32,
  parameter int AW      = 32,
  parameter int REG_AW  = 12,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*AW-1:0]   out_addr,
  output logic              out_miss
);
  logic              xlat_en;
  logic [CODE_W-1:0] size_code;
  logic [AW-1:0]     win_lo [NUM_WIN];
  logic [AW-1:0]     win_hi [NUM_WIN];

  ob_xlat_regs #(
    .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .DW(AW), .CODE_W(CODE_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .xlat_en(xlat_en), .size_code(size_code),
    .win_lo(win_lo), .win_hi(win_hi)
  );

  ob_xlat_lookup #(
    .NUM_WIN(NUM_WIN), .AW(AW), .CODE_W(CODE_W)
  ) u_lookup (
    .clk(clk), .rst(rst),
    .xlat_en(xlat_en), .size_code(size_code),
    .win_lo(win_lo), .win_hi(win_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_miss(out_miss)
  );
endmodule

// File: tb/test_ob_xlat_top.sv
`timescale 1ns/1ps
module test_ob_xlat_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr;
  logic        out_miss;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ob_xlat_top i_ob_xlat_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_miss(out_miss)
  );

  // {size code, local address, expected PCIe address, expected miss}
  localparam logic [99:0] VEC [10] = '{
    {3'd3, 32'h0012_3456, 64'h0000_00AA_8012_3456, 1'b0}, // R6 window 0
    {3'd3, 32'h0080_0010, 64'h0000_0000_0080_0010, 1'b1}, // R7 window 1 off
    {3'd3, 32'h02AB_CDEF, 64'h0000_0001_C02B_CDEF, 1'b0}, // R5 window 5
    {3'd3, 32'hFFFF_FFFF, 64'hFFFF_FFFF_F07F_FFFF, 1'b0}, // R5 last window
    {3'd3, 32'h1280_0000, 64'h0000_0001_C000_0000, 1'b0}, // R5 modulo wrap
    {3'd0, 32'h0050_1234, 64'h0000_0001_C000_1234, 1'b0}, // R2 1 MB
    {3'd0, 32'h0000_0ABC, 64'h0000_00AA_8000_0ABC, 1'b0}, // R6
    {3'd7, 32'h2FFF_FFFF, 64'h0000_0001_C7FF_FFFF, 1'b0}, // R2 128 MB
    {3'd7, 32'h0800_0000, 64'h0000_0000_0800_0000, 1'b1}, // R7
    {3'd0, 32'h01F0_0000, 64'hFFFF_FFFF_F000_0000, 1'b0}  // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R10 rvalid", 64'(reg_rvalid), 64'd1);
    d = reg_rdata;
  endtask

  task automatic look(input logic [31:0] a, output logic [63:0] oa, output logic om);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 out_valid", 64'(out_valid), 64'd1);
    oa = out_addr; om = out_miss;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] oa;
    logic        om;
    logic [2:0]  cur;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    rd(12'h004, d); chk("R1 cmd", 64'(d), 64'd0);
    rd(12'h030, d); chk("R1 size", 64'(d), 64'd0);
    rd(12'h200, d); chk("R1 win0 lo", 64'(d), 64'd0);
    rd(12'h2FC, d); chk("R1 win31 hi", 64'(d), 64'd0);
    look(32'h1234_5678, oa, om);
    chk("R1 pass addr", oa, 64'h0000_0000_1234_5678);
    chk("R1 miss", 64'(om), 64'd1);

    // program windows
    wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_00AA);
    wr(12'h208, 32'h1230_0000); wr(12'h20C, 32'h0000_0005);
    wr(12'h228, 32'hC000_0001); wr(12'h22C, 32'h0000_0001);
    wr(12'h2F8, 32'hF000_0001); wr(12'h2FC, 32'hFFFF_FFFF);
    rd(12'h2FC, d); chk("R4 win31 hi", 64'(d), 64'hFFFF_FFFF);
    rd(12'h208, d); chk("R4 win1 lo", 64'(d), 64'h1230_0000);

    // R3 only bit 1 is kept
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R3 cmd readback", 64'(d), 64'h2);
    // R2 only three bits kept
    wr(12'h030, 32'h0000_00FF);
    rd(12'h030, d); chk("R2 size readback", 64'(d), 64'h7);
    cur = 3'd7;

    // vector table
    foreach (VEC[i]) begin
      if (VEC[i][99:97] != cur) begin
        cur = VEC[i][99:97];
        wr(12'h030, 32'(cur));
      end
      look(VEC[i][96:65], oa, om);
      chk("R5/R6/R7 vec addr", oa, VEC[i][64:1]);
      chk("R5/R6/R7 vec miss", 64'(om), 64'(VEC[i][0]));
    end

    // R10 unmapped offset
    wr(12'h100, 32'hDEAD_BEEF);
    rd(12'h100, d); chk("R10 unmapped read", 64'(d), 64'd0);
    rd(12'h200, d); chk("R10 table untouched", 64'(d), 64'h8000_0001);
    rd(12'h030, d); chk("R10 size untouched", 64'(d), 64'h0);

    // R8 global disable
    wr(12'h004, 32'h0);
    look(32'h0000_0ABC, oa, om);
    chk("R8 pass addr", oa, 64'h0000_0000_0000_0ABC);
    chk("R8 miss", 64'(om), 64'd1);
    wr(12'h004, 32'h2);
    wr(12'h030, 32'h3);

    // R9 backpressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0012_3456;
    @(negedge clk);
    chk("R9 valid held", 64'(out_valid), 64'd1);
    chk("R9 in_ready low", 64'(in_ready), 64'd0);
    in_addr = 32'h02AB_CDEF;
    @(negedge clk);
    chk("R9 addr stable", out_addr, 64'h0000_00AA_8012_3456);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second addr", out_addr, 64'h0000_0001_C02B_CDEF);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);

    // R11 same-edge write and lookup use old table
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h210; reg_wdata = 32'h4000_0001;
    in_valid = 1'b1; in_addr = 32'h0100_0000;
    @(negedge clk);
    reg_wr = 1'b0; in_valid = 1'b0;
    chk("R11 old table addr", out_addr, 64'h0000_0000_0100_0000);
    chk("R11 old table miss", 64'(out_miss), 64'd1);
    look(32'h0100_0000, oa, om);
    chk("R11 new table addr", oa, 64'h0000_0000_4000_0000);
    chk("R11 new table miss", 64'(om), 64'd0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule